// File: doc/BRIEF.md
# NAND flash bus interface controller

This block sits between a simple memory-mapped register bus and a byte-wide NAND flash device. Software programs three strobe timing values and an enable/chip-enable control word. It then issues flash bus cycles by writing the command, address and data ports. A command write produces one latch cycle with the command-latch pin high. An address write produces the same cycle with the address-latch pin high. A data access produces one byte cycle, or four byte cycles when the access is 32 bits wide.

Every flash byte cycle has three phases: setup, strobe active and hold. Each phase length is programmed as a cycle count minus one. While a sequence runs, the register bus is held off: the acknowledge comes only after the last hold phase ends. The block also drives the active-low chip enable from a control bit and shows the ready/busy pin as a status bit. It gives a one-cycle pulse that clears an external ECC accumulator.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are 1, nf_cle, nf_ale and nf_dq_oe are 0, the configuration register (offset 0x00) reads 0x3770 and the control register (offset 0x04) reads 0x2.
- R2: The configuration register holds the setup count at bits [13:12], the active count at bits [10:8] and the hold count at bits [6:4], and all other bits read 0. The control register reads enable at bit 0 and chip-enable-off at bit 1, and all other bits read 0.
- R3: With the controller enabled, a write to offset 0x08 produces one flash cycle. nf_cle is high for (S+1)+(A+1)+(H+1) cycles and nf_we_n is low for A+1 cycles. nf_dq_o carries wdata[7:0] with nf_dq_oe high while nf_we_n is low, and nf_ale stays 0. S, A and H are the three configuration fields.
- R4: A write to offset 0x0C produces the same cycle with nf_ale high instead of nf_cle.
- R5: In each flash cycle the latch pin is high for S+1 cycles before nf_we_n falls and for H+1 cycles after nf_we_n rises.
- R6: A write to offset 0x10 with bus_wide=1 produces four write strobes, and the bytes go out least significant first. With bus_wide=0 it produces one strobe carrying wdata[7:0].
- R7: A read of offset 0x10 lowers nf_re_n for A+1 cycles per byte and samples nf_dq_i at the end of each low phase. A wide read returns the four bytes with the first byte in bits [7:0]. A narrow read returns the byte in bits [7:0] with zeros above.
- R8: bus_ack is a one-cycle pulse. Sampled on falling clock edges after bus_req is raised, it comes N*((S+1)+(A+1)+(H+1))+1 edges later for an access of N flash bytes, and 1 edge later for a register access.
- R9: While control bit 0 is 0, command, address and data accesses produce no strobe and no latch pulse. They are still acknowledged after 1 edge, and data reads return 0.
- R10: nf_ce_n follows control bit 1, so a saved control value written back restores the chip enable state.
- R11: The status register (offset 0x20) bit 0 reads the level of nf_rb.
- R12: Writing the control register with bit 4 set gives a one-cycle pulse on ecc_clr, and bit 4 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit data port access, 0 = byte |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 8*LANES | Write data |
| bus_rdata | output | 8*LANES | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access complete |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |
| ecc_clr | output | 1 | ECC accumulator clear pulse |

## Verification
A wrong phase counter or a wrong phase change shows in the same access as a latch or strobe pulse of the wrong length, and as a wrong acknowledge delay. A byte index that is stuck or miscounted shows as wrong byte order, a wrong number of strobes on nf_we_n or nf_re_n, or a wrong assembled read word. A lost enable or chip-enable state shows on the next flash access, or at once on nf_ce_n.

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic               bus_wide,
  input  logic [AW-1:0]      bus_addr,
  input  logic [8*LANES-1:0] bus_wdata,
  output logic [8*LANES-1:0] bus_rdata,
  output logic               bus_ack,
  output logic               nf_ce_n,
  output logic               nf_cle,
  output logic               nf_ale,
  output logic               nf_we_n,
  output logic               nf_re_n,
  output logic [7:0]         nf_dq_o,
  output logic               nf_dq_oe,
  input  logic [7:0]         nf_dq_i,
  input  logic               nf_rb,
  output logic               ecc_clr
);
  localparam int DW = 8 * LANES;
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [AW-1:0] A_CFG = AW'('h00);
  localparam logic [AW-1:0] A_CTL = AW'('h04);
  localparam logic [AW-1:0] A_CMD = AW'('h08);
  localparam logic [AW-1:0] A_ADR = AW'('h0C);
  localparam logic [AW-1:0] A_DAT = AW'('h10);
  localparam logic [AW-1:0] A_STA = AW'('h20);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_HOLD, S_DONE} st_t;
  st_t st;

  logic [1:0]    t_set;
  logic [2:0]    t_act, t_hld;
  logic          en, ce_off, ecc_q;
  logic [2:0]    cnt;
  logic [IW-1:0] idx, last;
  logic          k_cmd, k_adr, k_wr;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] reg_rd;

  wire sel_cmd = bus_addr == A_CMD;
  wire sel_adr = bus_addr == A_ADR;
  wire sel_dat = bus_addr == A_DAT;
  wire start   = en && (sel_dat || (bus_we && (sel_cmd || sel_adr)));
  wire in_seq  = (st == S_SETUP) || (st == S_ACT) || (st == S_HOLD);
  wire [2:0] lim = (st == S_SETUP) ? {1'b0, t_set} : (st == S_ACT) ? t_act : t_hld;
  wire phase_end = cnt == lim;

  always_comb begin
    reg_rd = '0;
    if (bus_addr == A_CFG) reg_rd = DW'({t_set, 1'b0, t_act, 1'b0, t_hld, 4'b0000});
    else if (bus_addr == A_CTL) reg_rd = DW'({ce_off, en});
    else if (bus_addr == A_STA) reg_rd = DW'(nf_rb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      t_set <= 2'd3;
      t_act <= 3'd7;
      t_hld <= 3'd7;
      en <= 1'b0;
      ce_off <= 1'b1;
      ecc_q <= 1'b0;
      cnt <= '0;
      idx <= '0;
      last <= '0;
      k_cmd <= 1'b0;
      k_adr <= 1'b0;
      k_wr <= 1'b0;
      buf_q <= '0;
      bus_rdata <= '0;
    end else begin
      ecc_q <= 1'b0;
      case (st)
        S_IDLE: if (bus_req) begin
          if (start) begin
            st <= S_SETUP;
            cnt <= '0;
            idx <= '0;
            k_cmd <= sel_cmd;
            k_adr <= sel_adr;
            k_wr <= bus_we;
            last <= (sel_dat && bus_wide) ? IW'(LANES - 1) : '0;
            buf_q <= bus_we ? bus_wdata : '0;
          end else begin
            st <= S_DONE;
            bus_rdata <= reg_rd;
            if (bus_we && bus_addr == A_CFG) begin
              t_set <= bus_wdata[13:12];
              t_act <= bus_wdata[10:8];
              t_hld <= bus_wdata[6:4];
            end
            if (bus_we && bus_addr == A_CTL) begin
              en <= bus_wdata[0];
              ce_off <= bus_wdata[1];
              ecc_q <= bus_wdata[4];
            end
          end
        end
        S_SETUP, S_ACT, S_HOLD: begin
          if (!phase_end) cnt <= cnt + 3'd1;
          else begin
            cnt <= '0;
            if (st == S_SETUP) st <= S_ACT;
            else if (st == S_ACT) begin
              st <= S_HOLD;
              if (!k_wr) buf_q[{idx, 3'b000} +: 8] <= nf_dq_i;
            end else if (idx == last) begin
              st <= S_DONE;
              bus_rdata <= buf_q;
            end else begin
              idx <= idx + 1'b1;
              st <= S_SETUP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_ack  = st == S_DONE;
  assign nf_ce_n  = ce_off;
  assign nf_cle   = in_seq && k_cmd;
  assign nf_ale   = in_seq && k_adr;
  assign nf_we_n  = !(st == S_ACT && k_wr);
  assign nf_re_n  = !(st == S_ACT && !k_wr);
  assign nf_dq_oe = k_wr && (st == S_ACT || st == S_HOLD);
  assign nf_dq_o  = buf_q[{idx, 3'b000} +: 8];
  assign ecc_clr  = ecc_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n)); // R3
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_dq_oe); // R3
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale)); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) bus_ack |=> !bus_ack); // R8
  AST_ECC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ecc_clr |=> !ecc_clr); // R12
endmodule

// File: tb/nand_bus_ctrl_test.sv
module nand_bus_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0, bus_wide = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_ack, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, ecc_clr;
  logic [7:0]  nf_dq_o, nf_dq_i;
  logic        nf_rb = 1;
  logic [31:0] rpat = 32'h11223344;
  int          rcount = 0;

  int n_chk = 0, n_fail = 0;
  int n_cle, n_ale, n_we, n_re, n_wep, n_rep, n_setup, n_post, bad_oe, n_ecc;
  logic [7:0] wb [4];
  logic prev_we = 1, prev_re = 1;

  always #2.5 clk = ~clk;

  nand_bus_ctrl uut (.*);

  assign nf_dq_i = rpat[rcount*8 +: 8];
  always @(posedge nf_re_n) if (rst_n) rcount = (rcount + 1) % 4;

  always @(posedge clk) begin
    if (nf_cle) n_cle++;
    if (nf_ale) n_ale++;
    if (!nf_we_n) n_we++;
    if (!nf_re_n) n_re++;
    if (ecc_clr) n_ecc++;
    if (!nf_we_n && !nf_dq_oe) bad_oe++;
    if (!nf_we_n && prev_we) begin
      if (n_wep < 4) wb[n_wep] = nf_dq_o;
      n_wep++;
    end
    if (!nf_re_n && prev_re) n_rep++;
    if ((nf_cle || nf_ale) && nf_we_n && nf_re_n) begin
      if (n_wep == 0 && n_rep == 0) n_setup++;
      else n_post++;
    end
    prev_we = nf_we_n;
    prev_re = nf_re_n;
  end

  task automatic clr_mon();
    n_cle = 0; n_ale = 0; n_we = 0; n_re = 0; n_wep = 0; n_rep = 0;
    n_setup = 0; n_post = 0; bad_oe = 0; n_ecc = 0; rcount = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [5:0] a, input logic we, input logic wide,
                     input logic [31:0] wd, output logic [31:0] rd, output int k);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wide = wide; bus_wdata = wd; bus_req = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!bus_ack && k < 2000);
    rd = bus_rdata;
    bus_req = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] rd; int k;
    chk("R1 ce_n", nf_ce_n, 1); chk("R1 we_n", nf_we_n, 1); chk("R1 re_n", nf_re_n, 1);
    chk("R1 cle", nf_cle, 0); chk("R1 ale", nf_ale, 0); chk("R1 oe", nf_dq_oe, 0);
    acc(6'h00, 0, 0, 0, rd, k); chk("R1 cfg", rd, 32'h3770);
    acc(6'h04, 0, 0, 0, rd, k); chk("R1 ctl", rd, 32'h2);
    chk("R8 reg ack", k, 1);
  endtask

  task automatic t_regs();
    logic [31:0] rd; int k;
    acc(6'h00, 1, 0, 32'h1250, rd, k); acc(6'h00, 0, 0, 0, rd, k); chk("R2 cfg", rd, 32'h1250);
    acc(6'h00, 1, 0, 32'hFFFFFFFF, rd, k); acc(6'h00, 0, 0, 0, rd, k); chk("R2 cfg mask", rd, 32'h3770);
    clr_mon();
    acc(6'h04, 1, 0, 32'hFFFFFFFF, rd, k);
    chk("R12 ecc pulse", n_ecc, 1);
    acc(6'h04, 0, 0, 0, rd, k); chk("R2 R12 ctl", rd, 32'h3);
  endtask

  task automatic t_cmd();
    logic [31:0] rd; int k;
    acc(6'h04, 1, 0, 32'h1, rd, k);
    acc(6'h00, 1, 0, 32'h1250, rd, k);
    clr_mon(); acc(6'h08, 1, 0, 32'h70, rd, k);
    chk("R3 cle", n_cle, 11); chk("R3 we", n_we, 3); chk("R3 ale", n_ale, 0);
    chk("R3 pulses", n_wep, 1); chk("R3 byte", wb[0], 8'h70); chk("R3 oe", bad_oe, 0);
    chk("R5 setup", n_setup, 2); chk("R5 hold", n_post, 6); chk("R8 cmd ack", k, 12);
    acc(6'h00, 1, 0, 32'h0, rd, k);
    clr_mon(); acc(6'h08, 1, 0, 32'hFF, rd, k);
    chk("R3 min cle", n_cle, 3); chk("R3 min we", n_we, 1); chk("R8 min ack", k, 4);
  endtask

  task automatic t_addr();
    logic [31:0] rd; int k;
    acc(6'h00, 1, 0, 32'h2310, rd, k);
    clr_mon(); acc(6'h0C, 1, 0, 32'h5A, rd, k);
    chk("R4 ale", n_ale, 9); chk("R4 cle", n_cle, 0); chk("R4 we", n_we, 4);
    chk("R4 byte", wb[0], 8'h5A); chk("R5 setup", n_setup, 3); chk("R5 hold", n_post, 2);
  endtask

  task automatic t_wr();
    logic [31:0] rd; int k;
    acc(6'h00, 1, 0, 32'h1110, rd, k);
    clr_mon(); acc(6'h10, 1, 1, 32'hA1B2C3D4, rd, k);
    chk("R6 pulses", n_wep, 4); chk("R6 b0", wb[0], 8'hD4); chk("R6 b1", wb[1], 8'hC3);
    chk("R6 b2", wb[2], 8'hB2); chk("R6 b3", wb[3], 8'hA1); chk("R6 we", n_we, 8);
    chk("R6 nolatch", n_cle + n_ale, 0); chk("R8 word ack", k, 25);
    clr_mon(); acc(6'h10, 1, 0, 32'h7777773C, rd, k);
    chk("R6 byte pulses", n_wep, 1); chk("R6 byte", wb[0], 8'h3C);
  endtask

  task automatic t_rd();
    logic [31:0] rd; int k;
    rpat = 32'h11223344;
    clr_mon(); acc(6'h10, 0, 1, 0, rd, k);
    chk("R7 word", rd, 32'h11223344); chk("R7 re", n_re, 8); chk("R7 pulses", n_rep, 4);
    chk("R7 no we", n_we, 0);
    rpat = 32'hDEADBE5A;
    clr_mon(); acc(6'h10, 0, 0, 0, rd, k);
    chk("R7 byte", rd, 32'h5A); chk("R7 byte pulses", n_rep, 1); chk("R8 byte ack", k, 7);
  endtask

  task automatic t_off();
    logic [31:0] rd; int k;
    acc(6'h04, 1, 0, 32'h0, rd, k);
    clr_mon(); acc(6'h08, 1, 0, 32'h90, rd, k);
    chk("R9 cmd ack", k, 1);
    acc(6'h10, 1, 1, 32'h12345678, rd, k);
    acc(6'h10, 0, 1, 0, rd, k);
    chk("R9 rd zero", rd, 0);
    chk("R9 no strobes", n_we + n_re + n_cle + n_ale, 0);
  endtask

  task automatic t_ce();
    logic [31:0] rd, saved; int k;
    acc(6'h04, 1, 0, 32'h1, rd, k); chk("R10 ce low", nf_ce_n, 0);
    acc(6'h04, 0, 0, 0, saved, k);
    acc(6'h04, 1, 0, saved | 32'h2, rd, k); chk("R10 ce off", nf_ce_n, 1);
    acc(6'h04, 1, 0, saved, rd, k); chk("R10 ce restore", nf_ce_n, 0);
  endtask

  task automatic t_stat();
    logic [31:0] rd; int k;
    nf_rb = 0; acc(6'h20, 0, 0, 0, rd, k); chk("R11 busy", rd, 0);
    nf_rb = 1; acc(6'h20, 0, 0, 0, rd, k); chk("R11 ready", rd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_regs(); t_cmd(); t_addr(); t_wr(); t_rd(); t_off(); t_ce(); t_stat();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule